// File: doc/BRIEF.md
# Indexed Clock Generator Configuration Bank

This block keeps the settings of a set of clock generators behind a single 32-bit control word on a simple memory-mapped bus. The word is indirect. A full-word write carries a generator index in its low nibble together with all the settings for that generator, and stores those settings into the indexed entry. A write that enables only the lowest byte lane changes only a read-select index. A read returns the entry that the read-select index points at, with that index placed in the low nibble.

Each entry holds seven fields: a 5-bit source select, generator enable, duty-cycle improve, output-off value, output enable, divide select and run-in-standby. From the enable, output-enable, run-in-standby and output-off bits, together with a chip-level `standby` input and a per-generator consumer clock request, the block computes a registered run request and a registered pin level for every generator. The downstream divider and pin logic use these values. The dividers, the source multiplexers and the clock-domain crossing are outside this block.

Top module: `clkgen_cfg_bank`

## Requirements
- R1: A write with `byte_en` = 4'b1111 whose index `wdata[3:0]` is below NUM_GEN replaces that entry from the same write. The fields are taken from these bit positions: source select from bits 12:8, generator enable from bit 16, duty-cycle improve from bit 17, output-off value from bit 18, output enable from bit 19, divide select from bit 20 and run-in-standby from bit 21. No other entry changes.
- R2: A full-word write also loads `wdata[3:0]` into the read-select index, whatever the value of that index.
- R3: A write with `byte_en` = 4'b0001 loads `wdata[3:0]` into the read-select index and leaves every entry unchanged.
- R4: A cycle with `rd_en` high makes `rdata` show, one clock later, the selected entry's fields at the positions given in R1, with the read-select index in bits 3:0.
- R5: After reset, entry 0 holds generator enable = 1 and source = 6, so it reads 0x00010600. Every other entry has all fields zero. The read-select index is 0, and `rdata`, `run_request` and `pin_level` are all zero.
- R6: Bits 31:22, 15:13 and 7:4 of `rdata` always read as zero. Values written into those bits are not stored.
- R7: A full-word write with an index of NUM_GEN or above changes no entry. A read while the read-select index is NUM_GEN or above returns 0x00000000.
- R8: A write with any `byte_en` pattern other than 4'b1111 or 4'b0001 changes neither the entries nor the read-select index.
- R9: In standby, an entry with output enable 0 drives `run_request` = generator enable AND `clock_request`. The run-in-standby bit has no effect in this case.
- R10: In standby, an entry with output enable 1 and run-in-standby 1 drives `run_request` = generator enable, whatever its clock request.
- R11: In standby, an entry with output enable 1 and run-in-standby 0 drives `run_request` = 0 and `pin_level` = its output-off value.
- R12: Outside standby, `run_request` = generator enable AND (`clock_request` OR output enable).
- R13: In every mode, `pin_level` equals the output-off value when output enable is 1 and `run_request` is 0, and is 0 otherwise. Both outputs are registered, so they follow their inputs one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| byte_en | input | 4 | Byte lane enables of the write |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; `rdata` updates on the next edge |
| rdata | output | 32 | Registered read data |
| standby | input | 1 | Chip standby mode |
| clock_request | input | NUM_GEN | Per-generator consumer clock request |
| run_request | output | NUM_GEN | Registered per-generator run request |
| pin_level | output | NUM_GEN | Registered per-generator static pin level |

## Verification
The assertions check on every cycle that the reserved read bits stay zero, that an out-of-range selection reads zero, and that ignored byte-lane patterns leave both the entries and the selection untouched. They also check, for each generator, the three standby cases (R9 to R11) and the reset state of the outputs. Only the bench's scenarios can show the indirect sequencing. Those scenarios cover a full write landing in the right entry and in no other, a lane-0 write redirecting later reads, the field packing of read data, and the mode behaviour outside standby. They run as a directed series followed by seeded random writes, reads and changes to standby and clock requests, each checked against a bench model of the bank.

// File: rtl/clkgen_cfg_pkg.sv
package clkgen_cfg_pkg;

  localparam int WORD_W  = 32;
  localparam int IDX_W   = 4;
  localparam int SRC_W   = 5;
  localparam int SRC_LSB = 8;
  localparam int FLG_LSB = 16;

  typedef struct packed {
    logic             run_stby;
    logic             div_sel;
    logic             out_en;
    logic             off_val;
    logic             duty_fix;
    logic             gen_en;
    logic [SRC_W-1:0] src;
  } gen_cfg_t;

  localparam int CFG_W = $bits(gen_cfg_t);

  function automatic gen_cfg_t word_to_cfg(input logic [WORD_W-1:0] w);
    gen_cfg_t c;
    c.src      = w[SRC_LSB +: SRC_W];
    c.gen_en   = w[FLG_LSB + 0];
    c.duty_fix = w[FLG_LSB + 1];
    c.off_val  = w[FLG_LSB + 2];
    c.out_en   = w[FLG_LSB + 3];
    c.div_sel  = w[FLG_LSB + 4];
    c.run_stby = w[FLG_LSB + 5];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] cfg_to_word(input gen_cfg_t c,
                                                    input logic [IDX_W-1:0] idx);
    logic [WORD_W-1:0] w;
    w = '0;
    w[IDX_W-1:0]          = idx;
    w[SRC_LSB +: SRC_W]   = c.src;
    w[FLG_LSB + 0]        = c.gen_en;
    w[FLG_LSB + 1]        = c.duty_fix;
    w[FLG_LSB + 2]        = c.off_val;
    w[FLG_LSB + 3]        = c.out_en;
    w[FLG_LSB + 4]        = c.div_sel;
    w[FLG_LSB + 5]        = c.run_stby;
    return w;
  endfunction

endpackage

// File: rtl/cfg_bus_decode.sv
module cfg_bus_decode
  import clkgen_cfg_pkg::*;
#(
  parameter int NUM_GEN = 8
) (
  input  logic              wr_en,
  input  logic [3:0]        byte_en,
  input  logic [WORD_W-1:0] wdata,
  output logic [NUM_GEN-1:0] entry_we,
  output logic              sel_we,
  output logic [IDX_W-1:0]  sel_val,
  output gen_cfg_t          wr_cfg
);

  localparam logic [3:0] BE_WORD = 4'b1111;
  localparam logic [3:0] BE_IDX  = 4'b0001;

  logic             full_wr;
  logic             idx_wr;
  logic [IDX_W-1:0] wr_idx;

  assign full_wr = wr_en && (byte_en == BE_WORD);
  assign idx_wr  = wr_en && (byte_en == BE_IDX);
  assign wr_idx  = wdata[IDX_W-1:0];
  assign sel_we  = full_wr || idx_wr;
  assign sel_val = wr_idx;
  assign wr_cfg  = word_to_cfg(wdata);

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_we
    assign entry_we[g] = full_wr && (wr_idx == IDX_W'(g));
  end

endmodule

// File: rtl/cfg_entry.sv
module cfg_entry
  import clkgen_cfg_pkg::*;
#(
  parameter logic             RST_EN  = 1'b0,
  parameter logic [SRC_W-1:0] RST_SRC = '0
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     we,
  input  gen_cfg_t wr_cfg,
  input  logic     standby,
  input  logic     clock_request,
  output gen_cfg_t cfg_q,
  output logic     run_request,
  output logic     pin_level
);

  gen_cfg_t rst_cfg;
  logic     run_d;
  logic     pin_d;

  always_comb begin
    rst_cfg        = '0;
    rst_cfg.gen_en = RST_EN;
    rst_cfg.src    = RST_SRC;
  end

  always_ff @(posedge clk) begin
    if (rst)     cfg_q <= rst_cfg;
    else if (we) cfg_q <= wr_cfg;
  end

  always_comb begin
    if (!cfg_q.gen_en)      run_d = 1'b0;
    else if (standby)       run_d = cfg_q.out_en ? cfg_q.run_stby : clock_request;
    else                    run_d = clock_request || cfg_q.out_en;
    pin_d = (cfg_q.out_en && !run_d) ? cfg_q.off_val : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_request <= 1'b0;
      pin_level   <= 1'b0;
    end else begin
      run_request <= run_d;
      pin_level   <= pin_d;
    end
  end

endmodule

// File: rtl/cfg_read_port.sv
module cfg_read_port
  import clkgen_cfg_pkg::*;
#(
  parameter int NUM_GEN = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd_en,
  input  logic [IDX_W-1:0]         sel_q,
  input  logic [NUM_GEN*CFG_W-1:0] cfg_flat,
  output logic [WORD_W-1:0]        rdata
);

  gen_cfg_t hit_cfg;
  logic     hit;

  always_comb begin
    hit_cfg = '0;
    hit     = 1'b0;
    for (int i = 0; i < NUM_GEN; i++) begin
      if (sel_q == IDX_W'(i)) begin
        hit_cfg = cfg_flat[i*CFG_W +: CFG_W];
        hit     = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= hit ? cfg_to_word(hit_cfg, sel_q) : '0;
  end

endmodule

// File: rtl/clkgen_cfg_bank.sv
module clkgen_cfg_bank
  import clkgen_cfg_pkg::*;
#(
  parameter int              NUM_GEN  = 8,
  parameter logic [SRC_W-1:0] GEN0_SRC = 5'd6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [3:0]         byte_en,
  input  logic [31:0]        wdata,
  input  logic               rd_en,
  output logic [31:0]        rdata,
  input  logic               standby,
  input  logic [NUM_GEN-1:0] clock_request,
  output logic [NUM_GEN-1:0] run_request,
  output logic [NUM_GEN-1:0] pin_level
);

  logic [NUM_GEN-1:0]       entry_we;
  logic                     sel_we;
  logic [IDX_W-1:0]         sel_val;
  logic [IDX_W-1:0]         sel_q;
  gen_cfg_t                 wr_cfg;
  logic [NUM_GEN*CFG_W-1:0] cfg_flat;
  logic [NUM_GEN-1:0]       gen_en_v;
  logic [NUM_GEN-1:0]       out_en_v;
  logic [NUM_GEN-1:0]       run_stby_v;
  logic [NUM_GEN-1:0]       off_val_v;

  cfg_bus_decode #(.NUM_GEN(NUM_GEN)) dec_i (
    .wr_en    (wr_en),
    .byte_en  (byte_en),
    .wdata    (wdata),
    .entry_we (entry_we),
    .sel_we   (sel_we),
    .sel_val  (sel_val),
    .wr_cfg   (wr_cfg)
  );

  always_ff @(posedge clk) begin
    if (rst)         sel_q <= '0;
    else if (sel_we) sel_q <= sel_val;
  end

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_ent
    gen_cfg_t cfg_q;
    cfg_entry #(
      .RST_EN  (g == 0),
      .RST_SRC ((g == 0) ? GEN0_SRC : '0)
    ) ent_i (
      .clk           (clk),
      .rst           (rst),
      .we            (entry_we[g]),
      .wr_cfg        (wr_cfg),
      .standby       (standby),
      .clock_request (clock_request[g]),
      .cfg_q         (cfg_q),
      .run_request   (run_request[g]),
      .pin_level     (pin_level[g])
    );
    assign cfg_flat[g*CFG_W +: CFG_W] = cfg_q;
    assign gen_en_v[g]   = cfg_q.gen_en;
    assign out_en_v[g]   = cfg_q.out_en;
    assign run_stby_v[g] = cfg_q.run_stby;
    assign off_val_v[g]  = cfg_q.off_val;
  end

  cfg_read_port #(.NUM_GEN(NUM_GEN)) rd_i (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .sel_q    (sel_q),
    .cfg_flat (cfg_flat),
    .rdata    (rdata)
  );

endmodule

// File: rtl/clkgen_cfg_bank_chk.sv
module clkgen_cfg_bank_chk
  import clkgen_cfg_pkg::*;
#(
  parameter int NUM_GEN = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     wr_en,
  input logic [3:0]               byte_en,
  input logic                     rd_en,
  input logic [31:0]              rdata,
  input logic                     standby,
  input logic [NUM_GEN-1:0]       clock_request,
  input logic [NUM_GEN-1:0]       run_request,
  input logic [NUM_GEN-1:0]       pin_level,
  input logic [IDX_W-1:0]         sel_q,
  input logic [NUM_GEN*CFG_W-1:0] cfg_flat,
  input logic [NUM_GEN-1:0]       gen_en_v,
  input logic [NUM_GEN-1:0]       out_en_v,
  input logic [NUM_GEN-1:0]       run_stby_v,
  input logic [NUM_GEN-1:0]       off_val_v
);

  p_reset_clear_r5: assert property (@(posedge clk)
    rst |=> (rdata == '0) && (run_request == '0) && (pin_level == '0) && (sel_q == '0));

  p_reserved_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (rdata[31:22] == '0) && (rdata[15:13] == '0) && (rdata[7:4] == '0));

  p_oob_read_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (int'(sel_q) >= NUM_GEN)) |=> (rdata == '0));

  p_lane_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (byte_en != 4'b1111) && (byte_en != 4'b0001)) |=> ($stable(sel_q) && $stable(cfg_flat)));

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_chk
    p_stby_no_out_r9: assert property (@(posedge clk) disable iff (rst)
      (standby && !out_en_v[g]) |=> (run_request[g] == $past(gen_en_v[g] && clock_request[g])));

    p_stby_keep_r10: assert property (@(posedge clk) disable iff (rst)
      (standby && gen_en_v[g] && out_en_v[g] && run_stby_v[g]) |=> run_request[g]);

    p_stby_hold_r11: assert property (@(posedge clk) disable iff (rst)
      (standby && out_en_v[g] && !run_stby_v[g])
        |=> (!run_request[g] && (pin_level[g] == $past(off_val_v[g]))));
  end

endmodule

bind clkgen_cfg_bank clkgen_cfg_bank_chk #(.NUM_GEN(NUM_GEN)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .wr_en         (wr_en),
  .byte_en       (byte_en),
  .rd_en         (rd_en),
  .rdata         (rdata),
  .standby       (standby),
  .clock_request (clock_request),
  .run_request   (run_request),
  .pin_level     (pin_level),
  .sel_q         (sel_q),
  .cfg_flat      (cfg_flat),
  .gen_en_v      (gen_en_v),
  .out_en_v      (out_en_v),
  .run_stby_v    (run_stby_v),
  .off_val_v     (off_val_v)
);

// File: tb/clkgen_cfg_bank_tb_top.sv
module clkgen_cfg_bank_tb_top;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [3:0]   byte_en = 4'h0;
  logic [31:0]  wdata = '0;
  logic         rd_en = 1'b0;
  logic [31:0]  rdata;
  logic         standby = 1'b0;
  logic [N-1:0] clock_request = '0;
  logic [N-1:0] run_request;
  logic [N-1:0] pin_level;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  // model: bit10 rs, 9 div, 8 oe, 7 oov, 6 dci, 5 en, 4:0 src
  logic [10:0] m_cfg [N];
  logic [3:0]  m_sel;

  always #5 clk = ~clk;

  clkgen_cfg_bank #(.NUM_GEN(N)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .byte_en(byte_en), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .standby(standby),
    .clock_request(clock_request), .run_request(run_request), .pin_level(pin_level)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  function automatic logic exp_run(int i);
    logic [10:0] c = m_cfg[i];
    if (!c[5])       return 1'b0;
    if (standby)     return c[8] ? c[10] : clock_request[i];
    return clock_request[i] | c[8];
  endfunction

  function automatic logic exp_pin(int i);
    logic [10:0] c = m_cfg[i];
    return (c[8] && !exp_run(i)) ? c[7] : 1'b0;
  endfunction

  function automatic logic [31:0] exp_rdata();
    if (m_sel >= 4'(N)) return 32'h0;
    return {10'b0, m_cfg[m_sel][10:5], 3'b0, m_cfg[m_sel][4:0], 4'b0, m_sel};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; byte_en = be; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; byte_en = 4'h0;
    if (be == 4'hF) begin
      m_sel = d[3:0];
      if (d[3:0] < 4'(N)) m_cfg[d[3:0]] = {d[21:16], d[12:8]};
    end else if (be == 4'h1) begin
      m_sel = d[3:0];
    end
  endtask

  task automatic read_check(input string req);
    logic [31:0] e;
    @(negedge clk);
    rd_en = 1'b1;
    e = exp_rdata();
    @(negedge clk);
    rd_en = 1'b0;
    check(rdata === e, req, rdata, e);
  endtask

  task automatic select_read(input int idx, input string req);
    bus_write(4'h1, 32'(idx));
    read_check(req);
  endtask

  task automatic outputs_check(input string req);
    logic [N-1:0] er, ep;
    for (int i = 0; i < N; i++) begin
      er[i] = exp_run(i);
      ep[i] = exp_pin(i);
    end
    @(negedge clk);
    check(run_request === er, {req, " run_request"}, 32'(run_request), 32'(er));
    check(pin_level === ep, {req, " pin_level"}, 32'(pin_level), 32'(ep));
  endtask

  // word builder: idx, src, en, dci, oov, oe, div, rs
  function automatic logic [31:0] mk(int idx, int src, bit en, bit dci, bit oov,
                                     bit oe, bit dv, bit rs);
    return {10'b0, rs, dv, oe, oov, dci, en, 3'b0, 5'(src), 4'b0, 4'(idx)};
  endfunction

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < N; i++) m_cfg[i] = '0;
    m_cfg[0] = {6'b000001, 5'd6};
    m_sel = 4'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R5: reset state
    check(rdata === 32'h0, "R5 rdata after reset", rdata, 32'h0);
    check(run_request === '0 && pin_level === '0, "R5 outputs after reset",
          32'({run_request, pin_level}), 32'h0);
    read_check("R5 entry0 reset read 0x00010600 via reset select");
    for (int i = 1; i < N; i++) select_read(i, "R5 R3 other entry reset read");

    // R1/R2/R4: full write into entry 3, other entries unchanged
    bus_write(4'hF, mk(3, 21, 1, 1, 0, 1, 1, 0));
    read_check("R2 R4 read after full write selects entry 3");
    select_read(2, "R1 neighbour entry 2 untouched");
    select_read(0, "R1 entry 0 untouched");

    // R6: reserved bits written as ones
    bus_write(4'hF, 32'hFFC0_E0F0 | mk(5, 31, 1, 0, 1, 0, 1, 1));
    read_check("R6 reserved bits read zero");

    // R7: out-of-range index
    bus_write(4'hF, mk(9, 7, 1, 1, 1, 1, 1, 1));
    read_check("R7 out-of-range select reads zero");
    for (int i = 0; i < N; i++) select_read(i, "R7 oob write changed no entry");

    // R8: other lane patterns
    bus_write(4'h1, 32'd3);
    bus_write(4'h2, mk(1, 1, 1, 1, 1, 1, 1, 1));
    bus_write(4'h3, 32'h0000_0006);
    bus_write(4'hE, mk(3, 1, 0, 0, 0, 0, 0, 0));
    read_check("R8 ignored lanes kept select and entry 3");

    // Standby cases on entry 4
    clock_request = '0;
    bus_write(4'hF, mk(4, 2, 1, 0, 1, 0, 0, 1));
    standby = 1'b1; clock_request[4] = 1'b1;
    outputs_check("R9 standby oe=0 follows request");
    clock_request[4] = 1'b0;
    outputs_check("R9 standby oe=0 no request");
    bus_write(4'hF, mk(4, 2, 1, 0, 1, 1, 0, 1));
    outputs_check("R10 standby oe rs keeps running");
    bus_write(4'hF, mk(4, 2, 1, 0, 1, 1, 0, 0));
    clock_request[4] = 1'b1;
    outputs_check("R11 standby oe !rs holds off value 1");
    bus_write(4'hF, mk(4, 2, 1, 0, 0, 1, 0, 0));
    outputs_check("R11 standby oe !rs holds off value 0");
    standby = 1'b0;
    outputs_check("R12 R13 out of standby oe runs");
    bus_write(4'hF, mk(4, 2, 0, 0, 1, 1, 0, 0));
    outputs_check("R13 disabled with oe drives off value");

    // random mix
    for (int k = 0; k < 600; k++) begin
      int op = int'($urandom_range(0, 9));
      standby = 1'($urandom_range(0, 1));
      clock_request = N'($urandom);
      case (op)
        0, 1, 2: bus_write(4'hF, $urandom);
        3:       bus_write(4'hF, $urandom & 32'h003F_1F07);
        4:       bus_write(4'h1, $urandom);
        5:       bus_write(4'($urandom), $urandom);
        default: ;
      endcase
      if (op >= 6) read_check("R4 R6 R7 random read");
      outputs_check("R9 R10 R11 R12 R13 random outputs");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule